// File: doc/BRIEF.md
# Banked Register File with Interrupt Context Bank

This block is the integer register store of a small processor core. Its 32-bit registers are grouped into banks of eight. There is a configurable number of numbered general banks and one extra bank reserved for interrupt context. Two read ports and one write port each address a register by a bank code and an index within the bank. Reads are combinational. A write takes effect at the clock edge, and a read of the same register in the same cycle already sees the new value.

The interrupt bank always uses the all-ones bank code. Numbered banks use codes from zero upward. Adding numbered banks therefore never moves the interrupt bank as software sees it.

When the core takes an interrupt, it pulses an entry strobe. In that single cycle the current accumulator is stored into interrupt-bank slot 0 and the program counter into slot 1. On return, a second strobe copies both slots onto dedicated restore outputs, where they stay until the next return.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads zero on both read ports, and both restore outputs are zero.
- R2: A write to numbered bank b (code 0 to NUM_BANKS-1), index i, is readable at bank b, index i on either read port from the next cycle. Banks are independent: the same index in another bank is unaffected.
- R3: The interrupt bank is addressed by the all-ones bank code (3'b111 by default) for both normal writes and reads. Its eight slots behave as ordinary registers.
- R4: With a bank code that is neither a configured numbered bank nor all-ones (4, 5 or 6 by default), a write changes no register and a read returns zero.
- R5: While irq_enter is high, the clock edge stores acc_in into interrupt slot 0 and pc_in into interrupt slot 1. No other register changes.
- R6: In the cycle after irq_return is high, acc_restore and pc_restore equal the contents of interrupt slots 0 and 1 as they stood before that edge. The restore outputs hold their value in every cycle after a cycle with irq_return low.
- R7: If a normal write targets interrupt slot 0 or 1 in the same cycle as irq_enter, the interrupt save is stored and the normal write is lost. A normal write to any other slot in that cycle still takes effect.
- R8: A read whose address equals the write address in the same cycle returns wr_data. A read of interrupt slot 0 or 1 while irq_enter is high returns acc_in or pc_in, and this save value wins over a same-cycle normal write.
- R9: The two read ports are independent and may address different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_bank | input | BANK_W (3) | Write bank code |
| wr_idx | input | IDX_W (3) | Write register index |
| wr_data | input | DATA_W (32) | Write data |
| rd_a_bank | input | BANK_W (3) | Read port A bank code |
| rd_a_idx | input | IDX_W (3) | Read port A index |
| rd_a_data | output | DATA_W (32) | Read port A data |
| rd_b_bank | input | BANK_W (3) | Read port B bank code |
| rd_b_idx | input | IDX_W (3) | Read port B index |
| rd_b_data | output | DATA_W (32) | Read port B data |
| irq_enter | input | 1 | Interrupt entry strobe: save context |
| acc_in | input | DATA_W (32) | Accumulator value to save |
| pc_in | input | DATA_W (32) | Program counter value to save |
| irq_return | input | 1 | Interrupt return strobe: restore context |
| acc_restore | output | DATA_W (32) | Restored accumulator |
| pc_restore | output | DATA_W (32) | Restored program counter |

## Verification
A wrong linear mapping of bank and index shows up as aliasing: a value written through one address reappears at another address on the next read. The bench reads neighbouring banks at the same index to expose it. A wrong priority between the save and a normal write leaves the wrong word in interrupt slot 0 or 1. That error is visible one cycle later on a read port, and on the restore outputs one cycle after the next return. Bypass faults are visible in the write cycle itself, because reads are combinational.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
    localparam int RD_PORTS = 2;
    localparam int CTX_SLOTS = 2;

    function automatic int ctx_bank_code(input int bank_w);
        return (1 << bank_w) - 1;
    endfunction
endpackage

// File: rtl/brf_addr_dec.sv
module brf_addr_dec #(
    parameter int NUM_BANKS = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BANK_W = 3,
    localparam int IDX_W = $clog2(REGS_PER_BANK),
    localparam int NREG = (NUM_BANKS + 1) * REGS_PER_BANK,
    localparam int LIN_W = $clog2(NREG)
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic [LIN_W-1:0]  lin
);
    import banked_rf_pkg::*;
    localparam int CTX_CODE = ctx_bank_code(BANK_W);
    localparam int CTX_BASE = NUM_BANKS * REGS_PER_BANK;

    always_comb begin
        hit = 1'b0;
        lin = '0;
        if (int'(bank) == CTX_CODE) begin
            hit = 1'b1;
            lin = LIN_W'(CTX_BASE + int'(idx));
        end else if (int'(bank) < NUM_BANKS) begin
            hit = 1'b1;
            lin = LIN_W'(int'(bank) * REGS_PER_BANK + int'(idx));
        end
    end
endmodule

// File: rtl/brf_read_port.sv
module brf_read_port #(
    parameter int NUM_BANKS = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BANK_W = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(REGS_PER_BANK),
    localparam int NREG = (NUM_BANKS + 1) * REGS_PER_BANK,
    localparam int LIN_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    input  logic [BANK_W-1:0]           bank,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        wr_hit,
    input  logic [LIN_W-1:0]            wr_lin,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        irq_enter,
    input  logic [DATA_W-1:0]           acc_in,
    input  logic [DATA_W-1:0]           pc_in,
    output logic [DATA_W-1:0]           rdata
);
    localparam int CTX_BASE = NUM_BANKS * REGS_PER_BANK;

    logic             rd_hit;
    logic [LIN_W-1:0] rd_lin;

    brf_addr_dec #(
        .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .BANK_W(BANK_W)
    ) u_dec (
        .bank(bank), .idx(idx), .hit(rd_hit), .lin(rd_lin)
    );

    always_comb begin
        if (!rd_hit)
            rdata = '0;
        else if (irq_enter && int'(rd_lin) == CTX_BASE)
            rdata = acc_in;
        else if (irq_enter && int'(rd_lin) == CTX_BASE + 1)
            rdata = pc_in;
        else if (wr_hit && wr_lin == rd_lin)
            rdata = wr_data;
        else
            rdata = regs[rd_lin];
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int NUM_BANKS = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BANK_W = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(REGS_PER_BANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_a_bank,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [BANK_W-1:0] rd_b_bank,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              irq_enter,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic              irq_return,
    output logic [DATA_W-1:0] acc_restore,
    output logic [DATA_W-1:0] pc_restore
);
    import banked_rf_pkg::*;
    localparam int NREG = (NUM_BANKS + 1) * REGS_PER_BANK;
    localparam int LIN_W = $clog2(NREG);
    localparam int CTX_BASE = NUM_BANKS * REGS_PER_BANK;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]           acc_rst;
        logic [DATA_W-1:0]           pc_rst;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic             wr_hit;
    logic [LIN_W-1:0] wr_lin;

    brf_addr_dec #(
        .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .BANK_W(BANK_W)
    ) u_wdec (
        .bank(wr_bank), .idx(wr_idx), .hit(wr_hit), .lin(wr_lin)
    );

    logic [RD_PORTS-1:0][BANK_W-1:0] rp_bank;
    logic [RD_PORTS-1:0][IDX_W-1:0]  rp_idx;
    logic [RD_PORTS-1:0][DATA_W-1:0] rp_data;

    assign rp_bank = {rd_b_bank, rd_a_bank};
    assign rp_idx  = {rd_b_idx, rd_a_idx};

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rport
        brf_read_port #(
            .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK),
            .BANK_W(BANK_W), .DATA_W(DATA_W)
        ) u_rp (
            .regs(st_q.regs), .bank(rp_bank[p]), .idx(rp_idx[p]),
            .wr_hit(wr_en && wr_hit), .wr_lin(wr_lin), .wr_data(wr_data),
            .irq_enter(irq_enter), .acc_in(acc_in), .pc_in(pc_in),
            .rdata(rp_data[p])
        );
    end

    assign rd_a_data = rp_data[0];
    assign rd_b_data = rp_data[1];

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_hit)
            st_d.regs[wr_lin] = wr_data;
        // context save is applied last so it overrides a colliding write
        if (irq_enter) begin
            st_d.regs[CTX_BASE]     = acc_in;
            st_d.regs[CTX_BASE + 1] = pc_in;
        end
        if (irq_return) begin
            st_d.acc_rst = st_q.regs[CTX_BASE];
            st_d.pc_rst  = st_q.regs[CTX_BASE + 1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_restore = st_q.acc_rst;
    assign pc_restore  = st_q.pc_rst;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int NUM_BANKS = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BANK_W = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(REGS_PER_BANK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [BANK_W-1:0] wr_bank,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [BANK_W-1:0] rd_a_bank,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [BANK_W-1:0] rd_b_bank,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              irq_enter,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] pc_in,
    input logic              irq_return,
    input logic [DATA_W-1:0] acc_restore,
    input logic [DATA_W-1:0] pc_restore
);
    localparam logic [BANK_W-1:0] CTX = '1;

    logic wr_valid_bank, wr_in_ctx_pair, b_bad_bank;
    assign wr_valid_bank  = (int'(wr_bank) < NUM_BANKS) || (wr_bank == CTX);
    assign wr_in_ctx_pair = (wr_bank == CTX) && (int'(wr_idx) < 2);
    assign b_bad_bank     = (int'(rd_b_bank) >= NUM_BANKS) && (rd_b_bank != CTX);

    // R8
    same_cycle_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid_bank && rd_a_bank == wr_bank && rd_a_idx == wr_idx
         && !(irq_enter && wr_in_ctx_pair)) |-> rd_a_data == wr_data);

    // R4
    bad_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_bad_bank |-> rd_b_data == '0);

    // R8
    save_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter && rd_b_bank == CTX && int'(rd_b_idx) == 1) |-> rd_b_data == pc_in);

    // R6
    restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_return |=> ($stable(acc_restore) && $stable(pc_restore)));

    // R5
    save_restore_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter && !irq_return) ##1
        (irq_return && !(wr_en && wr_bank == CTX && int'(wr_idx) == 0))
        |=> acc_restore == $past(acc_in, 2));
endmodule

bind banked_regfile banked_regfile_chk #(
    .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK),
    .BANK_W(BANK_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic        we;
        logic [2:0]  wb;
        logic [2:0]  wi;
        logic [31:0] wd;
        logic [2:0]  ab;
        logic [2:0]  ai;
        logic [2:0]  bb;
        logic [2:0]  bi;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 3'd3, 32'hA000_0003, 3'd0, 3'd3, 3'd1, 3'd3, 32'hA000_0003, 32'h0},
        '{1'b1, 3'd1, 3'd3, 32'hB100_0003, 3'd0, 3'd3, 3'd1, 3'd3, 32'hA000_0003, 32'hB100_0003},
        '{1'b1, 3'd3, 3'd7, 32'hC300_0007, 3'd3, 3'd7, 3'd1, 3'd3, 32'hC300_0007, 32'hB100_0003},
        '{1'b1, 3'd4, 3'd0, 32'hDEAD_0004, 3'd4, 3'd0, 3'd3, 3'd7, 32'h0,         32'hC300_0007},
        '{1'b1, 3'd7, 3'd5, 32'h7000_0005, 3'd7, 3'd5, 3'd4, 3'd0, 32'h7000_0005, 32'h0},
        '{1'b0, 3'd0, 3'd3, 32'hFFFF_FFFF, 3'd0, 3'd3, 3'd7, 3'd5, 32'hA000_0003, 32'h7000_0005},
        '{1'b1, 3'd6, 3'd2, 32'h0000_0066, 3'd6, 3'd2, 3'd2, 3'd2, 32'h0,         32'h0},
        '{1'b1, 3'd2, 3'd2, 32'h2222_2222, 3'd2, 3'd2, 3'd6, 3'd2, 32'h2222_2222, 32'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_bank = '0, wr_idx = '0, rd_a_bank = '0, rd_a_idx = '0;
    logic [2:0] rd_b_bank = '0, rd_b_idx = '0;
    logic [31:0] wr_data = '0, acc_in = '0, pc_in = '0;
    logic irq_enter = 1'b0, irq_return = 1'b0;
    logic [31:0] rd_a_data, rd_b_data, acc_restore, pc_restore;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_a_bank(rd_a_bank),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_bank(rd_b_bank),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .irq_enter(irq_enter),
        .acc_in(acc_in), .pc_in(pc_in), .irq_return(irq_return),
        .acc_restore(acc_restore), .pc_restore(pc_restore)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_rd(input logic [2:0] ab, input logic [2:0] ai,
                          input logic [2:0] bb, input logic [2:0] bi);
        rd_a_bank = ab; rd_a_idx = ai; rd_b_bank = bb; rd_b_idx = bi;
    endtask

    task automatic set_wr(input logic we, input logic [2:0] wb,
                          input logic [2:0] wi, input logic [31:0] wd);
        wr_en = we; wr_bank = wb; wr_idx = wi; wr_data = wd;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        set_rd(3'd0, 3'd0, 3'd7, 3'd7);
        #1;
        check("R1 bank0 idx0", rd_a_data, 32'h0);
        check("R1 ctx idx7", rd_b_data, 32'h0);
        check("R1 acc_restore", acc_restore, 32'h0);
        check("R1 pc_restore", pc_restore, 32'h0);

        // vector walk: R2 R3 R4 R8 R9
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            set_wr(VECS[v].we, VECS[v].wb, VECS[v].wi, VECS[v].wd);
            set_rd(VECS[v].ab, VECS[v].ai, VECS[v].bb, VECS[v].bi);
            #1;
            check("R2/R3/R4/R8 port A", rd_a_data, VECS[v].ea);
            check("R2/R4/R9 port B", rd_b_data, VECS[v].eb);
        end

        // R7 and R8: save colliding with write to ctx slot 0
        @(negedge clk);
        set_wr(1'b1, 3'd7, 3'd0, 32'h9999_9999);
        acc_in = 32'h1111_1111; pc_in = 32'h2222_0000; irq_enter = 1'b1;
        set_rd(3'd7, 3'd0, 3'd7, 3'd1);
        #1;
        check("R8 save bypass acc", rd_a_data, 32'h1111_1111);
        check("R8 save bypass pc", rd_b_data, 32'h2222_0000);
        @(negedge clk);
        set_wr(1'b0, 3'd0, 3'd0, 32'h0);
        irq_enter = 1'b0;
        #1;
        check("R7 save wins slot0", rd_a_data, 32'h1111_1111);
        check("R5 slot1 pc", rd_b_data, 32'h2222_0000);
        set_rd(3'd7, 3'd5, 3'd0, 3'd3);
        #1;
        check("R5 ctx slot5 untouched", rd_a_data, 32'h7000_0005);
        check("R5 bank0 untouched", rd_b_data, 32'hA000_0003);

        // R7: write to another ctx slot during save still lands
        @(negedge clk);
        set_wr(1'b1, 3'd7, 3'd2, 32'h2222_AAAA);
        acc_in = 32'h33; pc_in = 32'h44; irq_enter = 1'b1;
        @(negedge clk);
        set_wr(1'b0, 3'd0, 3'd0, 32'h0);
        irq_enter = 1'b0;
        set_rd(3'd7, 3'd2, 3'd7, 3'd0);
        #1;
        check("R7 other slot written", rd_a_data, 32'h2222_AAAA);
        check("R5 slot0 acc", rd_b_data, 32'h33);

        // R6: restore, hold, restore concurrent with new save
        irq_return = 1'b1;
        step();
        irq_return = 1'b0;
        check("R6 acc_restore", acc_restore, 32'h33);
        check("R6 pc_restore", pc_restore, 32'h44);
        set_wr(1'b1, 3'd7, 3'd0, 32'h55);
        step();
        set_wr(1'b0, 3'd0, 3'd0, 32'h0);
        check("R6 hold acc", acc_restore, 32'h33);
        irq_return = 1'b1; irq_enter = 1'b1;
        acc_in = 32'h77; pc_in = 32'h88;
        step();
        irq_return = 1'b0; irq_enter = 1'b0;
        check("R6 pre-edge acc", acc_restore, 32'h55);
        check("R6 pre-edge pc", pc_restore, 32'h44);
        set_rd(3'd7, 3'd0, 3'd7, 3'd1);
        #1;
        check("R5 new save acc", rd_a_data, 32'h77);
        check("R5 new save pc", rd_b_data, 32'h88);

        // R1: reset clears everything again
        rst_n = 1'b0;
        #1;
        check("R1 re-reset port A", rd_a_data, 32'h0);
        check("R1 re-reset restore", acc_restore, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule